// File: doc/BRIEF.md
# Digital Phase Detector and Pulse Separator for Disk Read Data

This block is the digital half of a disk read data separator. It takes the raw read pulse from the drive and the output of a local oscillator, which also clocks the block. It retimes the pulse into the oscillator domain, classifies each pulse as a clock bit or a data bit, and measures how far the pulse stream has drifted from the oscillator. It reports that drift as pump-up and pump-down pulses for an external loop filter. The oscillator and the filter lie outside the block.

Two 4-bit counters run on the oscillator clock. The reference counter runs freely and its terminal count flips a window flag between clock window and data window. The tracking counter is reloaded with a window-midpoint preset on every retimed pulse. The preset depends on the density select. The distance in clocks between the two terminal counts is the phase error.

A small state machine turns each measurement into one pump pulse. Its states are IDLE, ARMED, PUMP_UP and PUMP_DN. The transitions are:

- IDLE to ARMED on a retimed pulse.
- ARMED to IDLE when both terminal counts fall in the same cycle.
- ARMED to PUMP_UP when the tracking carry comes first.
- ARMED to PUMP_DN when the reference carry comes first.
- PUMP_UP to IDLE on the reference carry or when the width limit is reached.
- PUMP_DN to IDLE on the tracking carry or when the width limit is reached.

Top module: `dsep_top`

## Requirements
- R1: While rst_n is low, all five outputs are 0. This holds also when reset is applied in the middle of a pump pulse. Both counters restart at 0.
- R2: A rising edge of rd_raw that is sampled at clock edge E gives exactly one output pulse, one cycle wide, on sep_data or sep_clk. That pulse is visible in the cycle after the second edge following E.
- R3: The reference counter counts 0 to 15 and wraps. win_data is 0 after reset. It inverts after every cycle in which the reference counter is at 15, so its first change follows the 16th clock edge after reset.
- R4: A retimed pulse that falls in a cycle where win_data is 1 is reported on sep_data. Otherwise it is reported on sep_clk. The two are never 1 together.
- R5: The tracking counter is loaded in the cycle after a retimed pulse. The load value is 8 when dens_dbl is 0 and 12 when dens_dbl is 1. Its carry is the cycle in which it holds 15.
- R6: If the tracking carry comes d clocks before the reference carry, pump_up is 1 for min(d, 8) cycles. The pulse starts in the cycle after the tracking carry.
- R7: If the reference carry comes d clocks before the tracking carry, pump_dn is 1 for min(d, 8) cycles. The pulse starts in the cycle after the reference carry.
- R8: No pump pulse is longer than 8 cycles, however large the error.
- R9: When both carries fall in the same cycle, neither pump output goes to 1.
- R10: Without a retimed pulse, no pump pulse is produced. One pulse produces at most one pump pulse.
- R11: pump_up and pump_dn are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Local oscillator clock; clocks all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_raw | input | 1 | Raw read pulse from the drive, asynchronous |
| dens_dbl | input | 1 | Density select: 0 single, 1 double |
| pump_up | output | 1 | Speed-up request to the loop filter |
| pump_dn | output | 1 | Slow-down request to the loop filter |
| sep_data | output | 1 | One-cycle pulse for a bit found in the data window |
| sep_clk | output | 1 | One-cycle pulse for a bit found in the clock window |
| win_data | output | 1 | 1 while the data window is open |

## Verification
A fault in the reference counter or the window flag shows up within 16 cycles as a wrong win_data value. It also sends the next pulse to the wrong one of sep_data and sep_clk. A wrong tracking preset or a wrong carry order in the state machine shows up within one counter period after a pulse, as a pump pulse with the wrong sign or the wrong width. A stuck state shows up as a pump output held past 8 cycles, or as a pump pulse with no pulse to cause it. Driving pulses at every chosen reference phase in both densities exposes each of these within a few dozen cycles.

// File: rtl/dsep_pkg.sv
package dsep_pkg;

    // Phase detector states
    typedef enum logic [1:0] {
        PD_IDLE  = 2'd0,
        PD_ARMED = 2'd1,
        PD_UP    = 2'd2,
        PD_DN    = 2'd3
    } pd_state_t;

endpackage

// File: rtl/dsep_sync.sv
// Retimes an asynchronous pulse into the clock domain and emits a
// single-cycle strobe on each rising edge of the retimed level.
module dsep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic strobe_o
);
    logic [STAGES-1:0] stage_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= 1'b0;
                    else        stage_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= 1'b0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= stage_q[STAGES-1];
    end

    assign strobe_o = stage_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dsep_ctr.sv
// Wrapping up-counter with synchronous load and terminal-count flag.
module dsep_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         carry_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= load_val_i;
        else             cnt_q <= cnt_q + 1'b1;
    end

    assign carry_o = (cnt_q == TOP);
endmodule

// File: rtl/dsep_win.sv
// Window flag driven by the reference carry, and bit classification.
module dsep_win (
    input  logic clk,
    input  logic rst_n,
    input  logic carry_ref_i,
    input  logic strobe_i,
    output logic win_o,
    output logic sep_data_o,
    output logic sep_clk_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           win_o <= 1'b0;
        else if (carry_ref_i) win_o <= ~win_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sep_data_o <= 1'b0;
            sep_clk_o  <= 1'b0;
        end else begin
            sep_data_o <= strobe_i & win_o;
            sep_clk_o  <= strobe_i & ~win_o;
        end
    end
endmodule

// File: rtl/dsep_pd_fsm.sv
// Turns the order and spacing of two carries into one pump pulse.
module dsep_pd_fsm
    import dsep_pkg::*;
#(
    parameter int PUMP_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic carry_ref_i,
    input  logic carry_trk_i,
    output logic pump_up_o,
    output logic pump_dn_o
);
    localparam int PW = $clog2(PUMP_MAX + 1);
    localparam logic [PW-1:0] WLIM = PUMP_MAX[PW-1:0];

    pd_state_t     state_q, state_d;
    logic [PW-1:0] width_q;
    logic          at_limit;

    assign at_limit = (width_q == WLIM);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PD_IDLE;
        else        state_q <= state_d;
    end

    // pump width counter: primed while armed, advances while pumping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    width_q <= '0;
        else if (state_q == PD_ARMED)  width_q <= {{(PW-1){1'b0}}, 1'b1};
        else if (state_q == PD_UP || state_q == PD_DN)
                                       width_q <= width_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (strobe_i) state_d = PD_ARMED;
            end
            PD_ARMED: begin
                if (carry_ref_i && carry_trk_i) state_d = PD_IDLE;
                else if (carry_trk_i)           state_d = PD_UP;
                else if (carry_ref_i)           state_d = PD_DN;
            end
            PD_UP: begin
                if (carry_ref_i || at_limit) state_d = PD_IDLE;
            end
            PD_DN: begin
                if (carry_trk_i || at_limit) state_d = PD_IDLE;
            end
            default: state_d = PD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pump_up_o = 1'b0;
        pump_dn_o = 1'b0;
        unique case (state_q)
            PD_UP:   pump_up_o = 1'b1;
            PD_DN:   pump_dn_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/dsep_top.sv
module dsep_top #(
    parameter int CNT_W       = 4,
    parameter int PRE_SD      = 8,
    parameter int PRE_DD      = 12,
    parameter int PUMP_MAX    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic osc_clk,
    input  logic rst_n,
    input  logic rd_raw,
    input  logic dens_dbl,
    output logic pump_up,
    output logic pump_dn,
    output logic sep_data,
    output logic sep_clk,
    output logic win_data
);
    localparam logic [CNT_W-1:0] PSET_SD = PRE_SD[CNT_W-1:0];
    localparam logic [CNT_W-1:0] PSET_DD = PRE_DD[CNT_W-1:0];

    logic             strobe;
    logic             carry1;
    logic             carry2;
    logic [CNT_W-1:0] preset;

    assign preset = dens_dbl ? PSET_DD : PSET_SD;

    dsep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .din      (rd_raw),
        .strobe_o (strobe)
    );

    dsep_ctr #(.W(CNT_W)) u_ref_ctr (
        .clk        (osc_clk),
        .rst_n      (rst_n),
        .load_i     (1'b0),
        .load_val_i ({CNT_W{1'b0}}),
        .carry_o    (carry1)
    );

    dsep_ctr #(.W(CNT_W)) u_trk_ctr (
        .clk        (osc_clk),
        .rst_n      (rst_n),
        .load_i     (strobe),
        .load_val_i (preset),
        .carry_o    (carry2)
    );

    dsep_win u_win (
        .clk         (osc_clk),
        .rst_n       (rst_n),
        .carry_ref_i (carry1),
        .strobe_i    (strobe),
        .win_o       (win_data),
        .sep_data_o  (sep_data),
        .sep_clk_o   (sep_clk)
    );

    dsep_pd_fsm #(.PUMP_MAX(PUMP_MAX)) u_pd (
        .clk         (osc_clk),
        .rst_n       (rst_n),
        .strobe_i    (strobe),
        .carry_ref_i (carry1),
        .carry_trk_i (carry2),
        .pump_up_o   (pump_up),
        .pump_dn_o   (pump_dn)
    );
endmodule

// File: rtl/dsep_chk.sv
module dsep_chk #(
    parameter int PUMP_MAX = 8
) (
    input logic clk,
    input logic rst_n,
    input logic carry1,
    input logic carry2,
    input logic pump_up,
    input logic pump_dn,
    input logic sep_data,
    input logic sep_clk,
    input logic win_data
);
    logic [5:0] up_run;
    logic [5:0] dn_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_run <= '0;
            dn_run <= '0;
        end else begin
            up_run <= (pump_up && up_run != 6'h3f) ? up_run + 1'b1 : (pump_up ? up_run : '0);
            dn_run <= (pump_dn && dn_run != 6'h3f) ? dn_run + 1'b1 : (pump_dn ? dn_run : '0);
        end
    end

    // R11
    pumps_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_up && pump_dn));

    // R4
    sep_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sep_data && sep_clk));

    // R2
    sep_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sep_data || sep_clk) |=> !(sep_data || sep_clk));

    // R3
    win_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(win_data) |-> $past(carry1));

    // R6
    up_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_up) |-> $past(carry2));

    // R7
    dn_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_dn) |-> $past(carry1));

    // R8
    up_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(up_run) <= PUMP_MAX);

    // R8
    dn_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(dn_run) <= PUMP_MAX);
endmodule

bind dsep_top dsep_chk #(.PUMP_MAX(PUMP_MAX)) u_chk (
    .clk      (osc_clk),
    .rst_n    (rst_n),
    .carry1   (carry1),
    .carry2   (carry2),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .sep_data (sep_data),
    .sep_clk  (sep_clk),
    .win_data (win_data)
);

// File: tb/test_dsep_top.sv
`timescale 1ns/1ps
module test_dsep_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_raw = 1'b0;
    logic dens_dbl = 1'b0;
    logic pump_up, pump_dn, sep_data, sep_clk, win_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dsep_top i_dsep_top (
        .osc_clk  (clk),
        .rst_n    (rst_n),
        .rd_raw   (rd_raw),
        .dens_dbl (dens_dbl),
        .pump_up  (pump_up),
        .pump_dn  (pump_dn),
        .sep_data (sep_data),
        .sep_clk  (sep_clk),
        .win_data (win_data)
    );

    // Reference phase and window, modelled from R3
    logic [3:0] ph_m;
    logic       win_m;
    always @(posedge clk) begin
        if (!rst_n) begin
            ph_m  <= 4'd0;
            win_m <= 1'b0;
        end else begin
            ph_m <= ph_m + 4'd1;
            if (ph_m == 4'd15) win_m <= ~win_m;
        end
    end

    // Fields: density, reference phase at the raw pulse, expected up and down widths.
    // Widths follow R5..R9: tracking carry lands 15-preset cycles after arming,
    // reference carry lands (12-phase) mod 16 cycles after arming.
    typedef struct packed {
        logic       dd;
        logic [3:0] ph;
        logic [3:0] up;
        logic [3:0] dn;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd5,  4'd0, 4'd0},
        '{1'b0, 4'd3,  4'd2, 4'd0},
        '{1'b0, 4'd8,  4'd0, 4'd3},
        '{1'b0, 4'd12, 4'd0, 4'd7},
        '{1'b0, 4'd13, 4'd8, 4'd0},
        '{1'b0, 4'd14, 4'd7, 4'd0},
        '{1'b1, 4'd0,  4'd8, 4'd0},
        '{1'b1, 4'd9,  4'd0, 4'd0},
        '{1'b1, 4'd11, 4'd0, 4'd2},
        '{1'b1, 4'd12, 4'd0, 4'd3}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run_vec(input vec_t v);
        logic wexp;
        int nu, nd, nboth;
        string tu, td;
        dens_dbl = v.dd;
        @(negedge clk);
        while (ph_m != v.ph) @(negedge clk);
        rd_raw = 1'b1;
        @(negedge clk);
        rd_raw = 1'b0;
        @(negedge clk);
        // strobe cycle: no separated output yet, window as modelled
        chk(win_data == win_m, "R3", "window flag", int'(win_data), int'(win_m));
        chk(!(sep_data || sep_clk), "R2", "early separated pulse",
            int'(sep_data || sep_clk), 0);
        wexp = win_m;
        @(negedge clk);
        chk(sep_data == wexp && sep_clk == !wexp, "R4", "classification data/clk",
            int'({sep_data, sep_clk}), int'({wexp, !wexp}));
        nu = 0; nd = 0; nboth = 0;
        for (int k = 0; k < 24; k++) begin
            if (pump_up) nu++;
            if (pump_dn) nd++;
            if (pump_up && pump_dn) nboth++;
            if (k == 1)
                chk(!(sep_data || sep_clk), "R2", "separated pulse width",
                    int'(sep_data || sep_clk), 0);
            @(negedge clk);
        end
        tu = (v.up == 4'd8) ? "R8" : "R6";
        td = "R7";
        if (v.up == 4'd0 && v.dn == 4'd0) begin
            tu = "R9";
            td = "R9";
        end
        chk(nu == int'(v.up), tu, "pump_up width", nu, int'(v.up));
        chk(nd == int'(v.dn), td, "pump_dn width", nd, int'(v.dn));
        chk(nboth == 0, "R11", "pumps overlap", nboth, 0);
        if (v.dd)
            chk(nu == int'(v.up) && nd == int'(v.dn), "R5", "double density preset",
                nu - nd, int'(v.up) - int'(v.dn));
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int nu, nd;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({pump_up, pump_dn, sep_data, sep_clk, win_data} == 5'b0, "R1",
            "outputs in reset", int'({pump_up, pump_dn, sep_data, sep_clk, win_data}), 0);
        rst_n = 1'b1;

        // R10 and R3: idle line, window follows the reference count
        nu = 0; nd = 0;
        for (int k = 0; k < 40; k++) begin
            if (pump_up) nu++;
            if (pump_dn) nd++;
            @(negedge clk);
        end
        chk(nu + nd == 0, "R10", "pumps without pulse", nu + nd, 0);
        chk(win_data == win_m, "R3", "window after idle", int'(win_data), int'(win_m));

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset asserted in the middle of a pump pulse
        dens_dbl = 1'b1;
        @(negedge clk);
        while (ph_m != 4'd0) @(negedge clk);
        rd_raw = 1'b1;
        @(negedge clk);
        rd_raw = 1'b0;
        for (int k = 0; k < 30 && !pump_up; k++) @(negedge clk);
        chk(pump_up == 1'b1, "R6", "pump_up before reset", int'(pump_up), 1);
        rst_n = 1'b0;
        #1;
        chk({pump_up, pump_dn, sep_data, sep_clk, win_data} == 5'b0, "R1",
            "outputs after mid-pump reset",
            int'({pump_up, pump_dn, sep_data, sep_clk, win_data}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        nu = 0;
        for (int k = 0; k < 20; k++) begin
            if (pump_up || pump_dn) nu++;
            @(negedge clk);
        end
        chk(nu == 0, "R10", "no pump after reset", nu, 0);

        done = 1'b1;
        summary();
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

endmodule